// File: doc/BRIEF.md
# Audio Channel Count Converter

This block adapts the channel count of audio sample streams travelling between a multichannel sample interface and a serial audio port. It has two independent lanes, one for the playback direction and one for the capture direction. Each lane takes a valid/ready stream of signed samples, one sample per beat with a last-in-frame flag. It passes the stream through unchanged, folds stereo pairs into mono, or widens mono samples into stereo pairs.

Each lane has its own operation select, its own stereo-to-mono pick and its own fill choice for mono-to-stereo. A lane samples these settings when it accepts the first beat of a frame and holds them until that frame is finished. A lane holds at most one output register and one held sample, so its storage is a pipeline stage and nothing more. The sample width is a parameter restricted to 8, 16 or 32 bits. Any other width stops elaboration.

Top module: `chan_adapt`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, both out_valid outputs are low.
- R2: Operation code 0 (and code 3, treated the same) passes every input beat to the output unchanged, with its own last flag. In this mode a frame ends on the beat that carries last.
- R3: Operation code 1 takes input beats in pairs. The first beat of a pair is channel 0 and the second is channel 1. Pick code 0 (and code 3) outputs channel 0, and pick code 1 outputs channel 1.
- R4: Pick code 2 outputs the signed average of the two channels, rounded toward negative infinity. It is computed with one extra bit, so it never wraps, even for full-scale inputs of either sign.
- R5: In operation code 1 the lane emits exactly one output beat per input pair, always with last set. The last flags on the input beats are ignored.
- R6: Operation code 2 turns each input beat into two output beats. The first carries the sample with last clear. The second has last set and carries zero when fill is 0, or a copy of the sample when fill is 1.
- R7: An output beat stays stable while out_ready is low. In operation code 2, in_ready is low in the cycle after an input beat is accepted, because the second beat is still pending.
- R8: The operation, pick and fill settings take effect only at a frame boundary. A change made between the two beats of a pair, or within a pass-through frame that has not yet seen last, applies only from the next frame.
- R9: The playback and capture lanes operate independently. Each lane has its own settings and streams, and neither lane affects the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_op | input | 2 | Playback operation: 0 pass, 1 reduce, 2 expand, 3 pass |
| pb_pick | input | 2 | Playback reduce pick: 0 ch0, 1 ch1, 2 average, 3 ch0 |
| pb_fill | input | 1 | Playback expand fill: 0 zero, 1 copy |
| pb_in_valid | input | 1 | Playback input beat valid |
| pb_in_ready | output | 1 | Playback input beat accepted when high with valid |
| pb_in_data | input | SAMPLE_W | Playback input sample, signed |
| pb_in_last | input | 1 | Playback input last-in-frame |
| pb_out_valid | output | 1 | Playback output beat valid |
| pb_out_ready | input | 1 | Playback output beat consumer ready |
| pb_out_data | output | SAMPLE_W | Playback output sample, signed |
| pb_out_last | output | 1 | Playback output last-in-frame |
| cap_op | input | 2 | Capture operation, same encoding as pb_op |
| cap_pick | input | 2 | Capture reduce pick, same encoding as pb_pick |
| cap_fill | input | 1 | Capture expand fill, same encoding as pb_fill |
| cap_in_valid | input | 1 | Capture input beat valid |
| cap_in_ready | output | 1 | Capture input beat accepted when high with valid |
| cap_in_data | input | SAMPLE_W | Capture input sample, signed |
| cap_in_last | input | 1 | Capture input last-in-frame |
| cap_out_valid | output | 1 | Capture output beat valid |
| cap_out_ready | input | 1 | Capture output beat consumer ready |
| cap_out_data | output | SAMPLE_W | Capture output sample, signed |
| cap_out_last | output | 1 | Capture output last-in-frame |

## Verification
Pass-through frames of three beats show whether the last flag is carried per beat. Pairs with distinct channel values show whether the pick selects the right half. Average pairs at both full-scale extremes, and at mixed-sign small values such as -1 with 0 and 3 with -6, separate floor rounding from truncation and expose any wrap in the sum. Expansion runs under random output stalls separate zero fill from copy fill and show whether input is taken while a second beat is pending. Settings changed between the two beats of a pair, or inside an open pass-through frame, show whether the lane waits for the frame boundary. Both lanes run concurrently in different modes, which shows that they are independent.

// File: rtl/chan_adapt_pkg.sv
package chan_adapt_pkg;

   localparam int NUM_DIR  = 2;
   localparam int DIR_PLAY = 0;
   localparam int DIR_CAP  = 1;

   typedef enum logic [1:0] {
      OP_PASS     = 2'd0,
      OP_REDUCE   = 2'd1,
      OP_EXPAND   = 2'd2,
      OP_PASS_ALT = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      PICK_CH0     = 2'd0,
      PICK_CH1     = 2'd1,
      PICK_AVG     = 2'd2,
      PICK_CH0_ALT = 2'd3
   } pick_e;

endpackage

// File: rtl/chan_pair_reduce.sv
module chan_pair_reduce
   import chan_adapt_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] ch0,
   input  logic [SAMPLE_W-1:0] ch1,
   input  pick_e               pick,
   output logic [SAMPLE_W-1:0] mono
);

   localparam int SUM_W = SAMPLE_W + 1;

   if (SAMPLE_W < 2) begin : g_bad_w
      $error("chan_pair_reduce: SAMPLE_W must be at least 2");
   end

   // sum carries one guard bit so the midpoint of two extremes never wraps
   logic signed [SUM_W-1:0] sum;
   assign sum = $signed({ch0[SAMPLE_W-1], ch0}) + $signed({ch1[SAMPLE_W-1], ch1});

   always_comb begin
      case (pick)
         PICK_CH1: mono = ch1;
         PICK_AVG: mono = SAMPLE_W'(sum >>> 1);
         default:  mono = ch0;
      endcase
   end

endmodule

// File: rtl/chan_lane.sv
module chan_lane
   import chan_adapt_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_op,
   input  logic [1:0]          cfg_pick,
   input  logic                cfg_fill,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_data,
   input  logic                in_last,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [SAMPLE_W-1:0] out_data,
   output logic                out_last
);

   op_e                 op_q, eff_op;
   pick_e               pick_q, eff_pick;
   logic                fill_q;
   logic                mid_q;     // inside a frame: half pair held or pass frame open
   logic                pend_q;    // expanded second beat still to be emitted
   logic [SAMPLE_W-1:0] hold_q;
   logic [SAMPLE_W-1:0] red_data;
   logic                at_bound, can_load, take;

   assign at_bound = !mid_q && !pend_q;
   assign eff_op   = at_bound ? op_e'(cfg_op)     : op_q;
   assign eff_pick = at_bound ? pick_e'(cfg_pick) : pick_q;
   assign can_load = !out_valid || out_ready;

   always_comb begin
      case (eff_op)
         OP_REDUCE: in_ready = mid_q ? can_load : 1'b1;
         OP_EXPAND: in_ready = can_load && !pend_q;
         default:   in_ready = can_load;
      endcase
   end

   assign take = in_valid && in_ready;

   chan_pair_reduce #(.SAMPLE_W(SAMPLE_W)) u_reduce (
      .ch0  (hold_q),
      .ch1  (in_data),
      .pick (eff_pick),
      .mono (red_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q      <= OP_PASS;
         pick_q    <= PICK_CH0;
         fill_q    <= 1'b0;
         mid_q     <= 1'b0;
         pend_q    <= 1'b0;
         hold_q    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         if (take && at_bound) begin
            op_q   <= op_e'(cfg_op);
            pick_q <= pick_e'(cfg_pick);
            fill_q <= cfg_fill;
         end
         if (out_ready) out_valid <= 1'b0;
         if (pend_q) begin
            if (can_load) begin
               out_valid <= 1'b1;
               out_data  <= fill_q ? hold_q : '0;
               out_last  <= 1'b1;
               pend_q    <= 1'b0;
            end
         end else if (take) begin
            case (eff_op)
               OP_REDUCE: begin
                  if (!mid_q) begin
                     hold_q <= in_data;
                     mid_q  <= 1'b1;
                  end else begin
                     out_valid <= 1'b1;
                     out_data  <= red_data;
                     out_last  <= 1'b1;
                     mid_q     <= 1'b0;
                  end
               end
               OP_EXPAND: begin
                  out_valid <= 1'b1;
                  out_data  <= in_data;
                  out_last  <= 1'b0;
                  hold_q    <= in_data;
                  pend_q    <= 1'b1;
               end
               default: begin
                  out_valid <= 1'b1;
                  out_data  <= in_data;
                  out_last  <= in_last;
                  mid_q     <= !in_last;
               end
            endcase
         end
      end
   end

   // signed bounds of the pair, used only by the average check
   logic signed [SAMPLE_W-1:0] lo_s, hi_s;
   always_comb begin
      if ($signed(hold_q) < $signed(in_data)) begin
         lo_s = $signed(hold_q);
         hi_s = $signed(in_data);
      end else begin
         lo_s = $signed(in_data);
         hi_s = $signed(hold_q);
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last))
      else $error("output beat changed under stall"); // R7

   AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_last && pend_q && op_q == OP_EXPAND |=> out_valid && out_last)
      else $error("expanded second beat missing"); // R6

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !at_bound |=> $stable(op_q) && $stable(pick_q) && $stable(fill_q))
      else $error("settings changed inside a frame"); // R8

   AST_REDUCE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && op_q == OP_REDUCE |-> out_last)
      else $error("reduced beat without last"); // R5

   AST_AVG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      take && mid_q && eff_op == OP_REDUCE && eff_pick == PICK_AVG |->
         $signed(red_data) >= lo_s && $signed(red_data) <= hi_s)
      else $error("average outside channel range"); // R4

endmodule

// File: rtl/chan_adapt.sv
module chan_adapt
   import chan_adapt_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          pb_op,
   input  logic [1:0]          pb_pick,
   input  logic                pb_fill,
   input  logic                pb_in_valid,
   output logic                pb_in_ready,
   input  logic [SAMPLE_W-1:0] pb_in_data,
   input  logic                pb_in_last,
   output logic                pb_out_valid,
   input  logic                pb_out_ready,
   output logic [SAMPLE_W-1:0] pb_out_data,
   output logic                pb_out_last,
   input  logic [1:0]          cap_op,
   input  logic [1:0]          cap_pick,
   input  logic                cap_fill,
   input  logic                cap_in_valid,
   output logic                cap_in_ready,
   input  logic [SAMPLE_W-1:0] cap_in_data,
   input  logic                cap_in_last,
   output logic                cap_out_valid,
   input  logic                cap_out_ready,
   output logic [SAMPLE_W-1:0] cap_out_data,
   output logic                cap_out_last
);

   if (!(SAMPLE_W == 8 || SAMPLE_W == 16 || SAMPLE_W == 32)) begin : g_bad_width
      $error("chan_adapt: SAMPLE_W must be 8, 16 or 32");
   end

   logic [1:0]          op_a    [NUM_DIR];
   logic [1:0]          pick_a  [NUM_DIR];
   logic                fill_a  [NUM_DIR];
   logic                iv_a    [NUM_DIR];
   logic                ir_a    [NUM_DIR];
   logic [SAMPLE_W-1:0] id_a    [NUM_DIR];
   logic                il_a    [NUM_DIR];
   logic                ov_a    [NUM_DIR];
   logic                ordy_a  [NUM_DIR];
   logic [SAMPLE_W-1:0] od_a    [NUM_DIR];
   logic                ol_a    [NUM_DIR];

   assign op_a[DIR_PLAY]   = pb_op;
   assign pick_a[DIR_PLAY] = pb_pick;
   assign fill_a[DIR_PLAY] = pb_fill;
   assign iv_a[DIR_PLAY]   = pb_in_valid;
   assign id_a[DIR_PLAY]   = pb_in_data;
   assign il_a[DIR_PLAY]   = pb_in_last;
   assign ordy_a[DIR_PLAY] = pb_out_ready;
   assign pb_in_ready      = ir_a[DIR_PLAY];
   assign pb_out_valid     = ov_a[DIR_PLAY];
   assign pb_out_data      = od_a[DIR_PLAY];
   assign pb_out_last      = ol_a[DIR_PLAY];

   assign op_a[DIR_CAP]    = cap_op;
   assign pick_a[DIR_CAP]  = cap_pick;
   assign fill_a[DIR_CAP]  = cap_fill;
   assign iv_a[DIR_CAP]    = cap_in_valid;
   assign id_a[DIR_CAP]    = cap_in_data;
   assign il_a[DIR_CAP]    = cap_in_last;
   assign ordy_a[DIR_CAP]  = cap_out_ready;
   assign cap_in_ready     = ir_a[DIR_CAP];
   assign cap_out_valid    = ov_a[DIR_CAP];
   assign cap_out_data     = od_a[DIR_CAP];
   assign cap_out_last     = ol_a[DIR_CAP];

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
      chan_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_op    (op_a[d]),
         .cfg_pick  (pick_a[d]),
         .cfg_fill  (fill_a[d]),
         .in_valid  (iv_a[d]),
         .in_ready  (ir_a[d]),
         .in_data   (id_a[d]),
         .in_last   (il_a[d]),
         .out_valid (ov_a[d]),
         .out_ready (ordy_a[d]),
         .out_data  (od_a[d]),
         .out_last  (ol_a[d])
      );
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> !pb_out_valid && !cap_out_valid)
      else $error("output valid right after reset"); // R1

endmodule

// File: tb/test_chan_adapt.sv
module test_chan_adapt;
   localparam int W  = 16;
   localparam int ND = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0]   op   [ND];
   logic [1:0]   pick [ND];
   logic         fill [ND];
   logic         iv   [ND];
   logic         ir   [ND];
   logic [W-1:0] id   [ND];
   logic         il   [ND];
   logic         ov   [ND];
   logic         ordy [ND];
   logic [W-1:0] od   [ND];
   logic         ol   [ND];

   chan_adapt #(.SAMPLE_W(W)) i_chan_adapt (
      .clk(clk), .rst_n(rst_n),
      .pb_op(op[0]), .pb_pick(pick[0]), .pb_fill(fill[0]),
      .pb_in_valid(iv[0]), .pb_in_ready(ir[0]), .pb_in_data(id[0]), .pb_in_last(il[0]),
      .pb_out_valid(ov[0]), .pb_out_ready(ordy[0]), .pb_out_data(od[0]), .pb_out_last(ol[0]),
      .cap_op(op[1]), .cap_pick(pick[1]), .cap_fill(fill[1]),
      .cap_in_valid(iv[1]), .cap_in_ready(ir[1]), .cap_in_data(id[1]), .cap_in_last(il[1]),
      .cap_out_valid(ov[1]), .cap_out_ready(ordy[1]), .cap_out_data(od[1]), .cap_out_last(ol[1])
   );

   int    checks = 0;
   int    fails  = 0;
   string phase  = "R1";

   logic [W:0]   expq [ND][$];
   string        tagq [ND][$];
   bit           m_mid   [ND];
   logic [1:0]   m_op    [ND];
   logic [1:0]   m_pick  [ND];
   logic         m_fill  [ND];
   logic [W-1:0] m_first [ND];
   bit           pend_chk [ND];
   bit           stalled  [ND];
   logic [W:0]   stall_v  [ND];
   int           rdy_mode [ND];

   function automatic void push(int d, logic [W-1:0] v, logic l, string t);
      expq[d].push_back({l, v});
      tagq[d].push_back(t);
   endfunction

   // behavioural model of one accepted input beat
   function automatic void model_accept(int d);
      int a, b, s;
      if (!m_mid[d]) begin
         m_op[d] = op[d]; m_pick[d] = pick[d]; m_fill[d] = fill[d];
      end
      case (m_op[d])
         2'd1: begin
            if (!m_mid[d]) begin
               m_first[d] = id[d];
               m_mid[d]   = 1'b1;
            end else begin
               m_mid[d] = 1'b0;
               if (m_pick[d] == 2'd1) push(d, id[d], 1'b1, "R3,R5");
               else if (m_pick[d] == 2'd2) begin
                  a = $signed(m_first[d]);
                  b = $signed(id[d]);
                  s = (a + b) >>> 1;
                  push(d, s[W-1:0], 1'b1, "R4,R5");
               end else push(d, m_first[d], 1'b1, "R3,R5");
            end
         end
         2'd2: begin
            push(d, id[d], 1'b0, "R6");
            push(d, m_fill[d] ? id[d] : '0, 1'b1, "R6");
            pend_chk[d] = 1'b1;
         end
         default: begin
            push(d, id[d], il[d], "R2");
            m_mid[d] = !il[d];
         end
      endcase
   endfunction

   logic [W:0] e;
   string      t;
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < ND; d++) begin
            checks++;
            if (ov[d]) begin
               fails++;
               $display("FAIL R1 dir%0d: out_valid actual %0b expected 0 during reset", d, ov[d]);
            end
         end
      end else begin
         for (int d = 0; d < ND; d++) begin
            if (pend_chk[d]) begin
               checks++;
               if (ir[d]) begin
                  fails++;
                  $display("FAIL R7 dir%0d: in_ready actual 1 expected 0 with second beat pending", d);
               end
               pend_chk[d] = 1'b0;
            end
            if (stalled[d]) begin
               checks++;
               if (!ov[d] || {ol[d], od[d]} != stall_v[d]) begin
                  fails++;
                  $display("FAIL R7 dir%0d: stalled beat actual v=%0b %h expected v=1 %h",
                           d, ov[d], {ol[d], od[d]}, stall_v[d]);
               end
            end
            stalled[d] = ov[d] && !ordy[d];
            stall_v[d] = {ol[d], od[d]};
            if (ov[d] && ordy[d]) begin
               checks++;
               if (expq[d].size() == 0) begin
                  fails++;
                  $display("FAIL %s dir%0d: unexpected beat actual data=%0d last=%0b expected none",
                           phase, d, $signed(od[d]), ol[d]);
               end else begin
                  e = expq[d].pop_front();
                  t = tagq[d].pop_front();
                  if ({ol[d], od[d]} != e) begin
                     fails++;
                     $display("FAIL %s/%s dir%0d: actual data=%0d last=%0b expected data=%0d last=%0b",
                              t, phase, d, $signed(od[d]), ol[d], $signed(e[W-1:0]), e[W]);
                  end
               end
            end
            if (iv[d] && ir[d]) model_accept(d);
         end
      end
   end

   always @(posedge clk) begin
      #1;
      for (int d = 0; d < ND; d++)
         ordy[d] = (rdy_mode[d] == 0) ? 1'b1 : (($urandom % 3) != 0);
   end

   task automatic send(int d, int v, bit l);
      iv[d] = 1'b1;
      id[d] = v[W-1:0];
      il[d] = l;
      do @(negedge clk); while (!ir[d]);
      @(posedge clk);
      #1;
      iv[d] = 1'b0;
   endtask

   task automatic drain(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check_empty();
      for (int d = 0; d < ND; d++) begin
         checks++;
         if (expq[d].size() != 0) begin
            fails++;
            $display("FAIL %s dir%0d: beats missing actual %0d outstanding expected 0",
                     phase, d, expq[d].size());
         end
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   int av_a [7] = '{32767, -32768, -1, 1, -32768, 3, -3};
   int av_b [7] = '{32767, -32768, 0, 0, 32767, -6, -2};

   initial begin
      for (int d = 0; d < ND; d++) begin
         op[d] = 2'd0; pick[d] = 2'd0; fill[d] = 1'b0;
         iv[d] = 1'b0; id[d] = '0; il[d] = 1'b0; ordy[d] = 1'b1;
         rdy_mode[d] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1;
      for (int d = 0; d < ND; d++) begin
         checks++;
         if (ov[d]) begin
            fails++;
            $display("FAIL R1 dir%0d: out_valid actual 1 expected 0 after reset", d);
         end
      end

      // pass-through on playback, channel 0 pick on capture, concurrently
      phase = "R9";
      op[0] = 2'd0;
      op[1] = 2'd1; pick[1] = 2'd0;
      fork
         for (int i = 0; i < 9; i++) send(0, 100 * i - 250, (i % 3) == 2);
         for (int i = 0; i < 8; i++) send(1, 1000 + 7 * i, 1'b0);
      join
      drain(6); check_empty();

      // picks on playback (with ignored last flags), average corners on capture
      phase = "R4";
      op[0] = 2'd1; pick[0] = 2'd1; op[1] = 2'd1; pick[1] = 2'd2;
      fork
         begin
            for (int i = 0; i < 4; i++) begin
               send(0, -40 - i, 1'b1);
               send(0, 60 + i, 1'b0);
            end
            pick[0] = 2'd3;
            for (int i = 0; i < 3; i++) begin
               send(0, 500 + i, 1'b0);
               send(0, -500 - i, 1'b1);
            end
         end
         for (int i = 0; i < 7; i++) begin
            send(1, av_a[i], 1'b0);
            send(1, av_b[i], 1'b1);
         end
      join
      drain(6); check_empty();

      // expansion under random stalls: zero fill on playback, copy on capture
      phase = "R7";
      rdy_mode[0] = 1; rdy_mode[1] = 1;
      op[0] = 2'd2; fill[0] = 1'b0; op[1] = 2'd2; fill[1] = 1'b1;
      fork
         for (int i = 0; i < 12; i++) send(0, 3 * i - 17, 1'b0);
         for (int i = 0; i < 12; i++) send(1, -32768 + 4000 * i, 1'b1);
      join
      drain(40);
      rdy_mode[0] = 0; rdy_mode[1] = 0;
      drain(4); check_empty();

      // settings changed inside a frame apply only at the next frame
      phase = "R8";
      op[0] = 2'd0; op[1] = 2'd1; pick[1] = 2'd0;
      fork
         begin
            send(0, 5, 1'b0);
            op[0] = 2'd1; pick[0] = 2'd0;
            send(0, 6, 1'b1);
            send(0, 7, 1'b0);
            send(0, 8, 1'b0);
            op[0] = 2'd3;
            send(0, 9, 1'b0);
            send(0, 10, 1'b1);
         end
         begin
            send(1, 11, 1'b0);
            op[1] = 2'd2; fill[1] = 1'b1;
            send(1, 22, 1'b0);
            send(1, 33, 1'b1);
         end
      join
      drain(6); check_empty();

      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL %s watchdog: actual run still busy expected completion", phase);
      summary();
      $finish;
   end

endmodule